// File: doc/BRIEF.md
# Ladder-Predicted LFSR Up/Down Counter

This block is a synchronous up/down counter whose update path keeps the same depth whatever its total width. The count is held in a chain of small counting cells. Each cell is a 3-bit shift-register state machine with a fixed 8-state cycle, not a binary adder. Each cell advances when every cell below it sits at its terminal state for the current direction. That condition is not worked out by a ripple. It is held in registered predict flags, computed one cycle ahead from the next states of the lower cells.

Two flag sets are kept at the same time: one for counting up (carry) and one for counting down (borrow). A per-cell select picks between them using the direction input of the current cycle. The direction can therefore be reversed on any cycle with no bubble. In that case each cell's shift map runs backwards and the other flag set is selected.

A synchronous load takes a binary value, translates each 3-bit slice into its cell state, and rebuilds both flag sets from the loaded states. The count is presented in binary, decoded from the cell states through a per-cell lookup. Two one-cycle flags mark a coming wrap at the top and at the bottom.

Top module: `ladder_updown_counter`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the count output is 0, and carry_o and borrow_o are low whenever en is low.
- R2: When en is high, load is low and dir_up is 1, the count increases by one at the next rising edge, modulo 2^WIDTH.
- R3: When en is high, load is low and dir_up is 0, the count decreases by one at the next rising edge, modulo 2^WIDTH.
- R4: When en and load are both low, the count keeps its value at the next edge.
- R5: When load is high, the count takes load_val at the next edge, whatever en and dir_up are (load has priority).
- R6: carry_o is high exactly when en=1, dir_up=1, load=0 and the count is 2^WIDTH-1. The next edge then takes the count to 0.
- R7: borrow_o is high exactly when en=1, dir_up=0, load=0 and the count is 0. The next edge then takes the count to 2^WIDTH-1.
- R8: The direction may change on any cycle, including at cell boundaries (count values that are multiples of 8, and the values just below them). Each step still moves by exactly one in the newly chosen direction.
- R9: carry_o and borrow_o stay low in every cycle where the conditions of R6 and R7 are not met, including at the extreme values when the counter is disabled, loading, or moving away from the extreme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| load | input | 1 | Synchronous parallel load, priority over en |
| load_val | input | WIDTH | Binary value to load |
| count | output | WIDTH | Current count in binary |
| carry_o | output | 1 | Next edge wraps from the top to 0 |
| borrow_o | output | 1 | Next edge wraps from 0 to the top |

## Verification
The bench builds the counter with its default of six cells, giving an 18-bit count. This makes the full-width wrap at 2^18-1, and the borrow back up to it, reachable with a load followed by a few steps. The directed scenarios put reversals right at the 3-bit cell boundaries, where a cell below has to be at its terminal state for the predict flag of the cell above to fire. A long run of mixed random directions, enables and loads then compares the decoded count every cycle against a plain integer model.

// File: rtl/ladder_counter_pkg.sv
// Package: shared cell type and the cell state-machine functions.
// Each cell is a 3-bit left-shifting feedback register. Its feedback adds
// an extra term that inserts the all-zero state, so the cell walks a single
// cycle of 8 states:
//   000 -> 001 -> 010 -> 101 -> 011 -> 111 -> 110 -> 100 -> 000
// The position in this cycle is the binary value of the cell digit.
// Assumes: a cell of exactly 3 bits; the feedback taps below are fixed for it.
package ladder_counter_pkg;

    localparam int CELL_BITS   = 3;
    localparam int CELL_STATES = 1 << CELL_BITS;

    typedef logic [CELL_BITS-1:0] cell_t;

    // Terminal state when stepping up (digit 7) and when stepping down (digit 0).
    localparam cell_t TERM_UP = 3'b100;
    localparam cell_t TERM_DN = 3'b000;

    // Upward step: shift left, feed in the tap XOR plus the zero-insert term.
    function automatic cell_t cell_up(input cell_t s);
        logic fb;
        fb = s[2] ^ s[1] ^ (s[1:0] == 2'b00);
        return {s[1:0], fb};
    endfunction

    // Downward step: the exact inverse of cell_up, found among all states.
    function automatic cell_t cell_dn(input cell_t s);
        cell_t r;
        r = '0;
        for (int k = 0; k < CELL_STATES; k++) begin
            if (cell_up(cell_t'(k)) == s) r = cell_t'(k);
        end
        return r;
    endfunction

    // Binary digit to cell state: walk up from the zero state v times.
    function automatic cell_t cell_enc(input logic [CELL_BITS-1:0] v);
        cell_t s;
        s = TERM_DN;
        for (int k = 0; k < CELL_STATES - 1; k++) begin
            if (k < int'(v)) s = cell_up(s);
        end
        return s;
    endfunction

    // Cell state to binary digit: position of the state in the cycle.
    function automatic logic [CELL_BITS-1:0] cell_dec(input cell_t s);
        cell_t                t;
        logic [CELL_BITS-1:0] v;
        t = TERM_DN;
        v = '0;
        for (int k = 0; k < CELL_STATES; k++) begin
            if (t == s) v = CELL_BITS'(k);
            t = cell_up(t);
        end
        return v;
    endfunction

endpackage

// File: rtl/lfsr_cell.sv
// One counting cell. It holds a 3-bit shift-register state and moves it one
// place up or down the cycle when step is high, or takes a loaded state.
// The next state is exported so the predictor can work one cycle ahead.
// Assumes: step is already qualified by enable and by the predict flag.
module lfsr_cell
    import ladder_counter_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  cell_t load_state,
    input  logic  step,
    input  logic  dir_up,
    output cell_t state,
    output cell_t state_nxt
);

    // Next-state choice: load first, then a step in the chosen direction.
    always_comb begin
        if (load)
            state_nxt = load_state;
        else if (step)
            state_nxt = dir_up ? cell_up(state) : cell_dn(state);
        else
            state_nxt = state;
    end

    // State register, cleared to the zero-digit state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TERM_DN;
        else
            state <= state_nxt;
    end

endmodule

// File: rtl/ladder_predict.sv
// Registered carry/borrow predictors for every rung of the ladder.
// Bit i of pred_up is high when all cells below i sit at their upward
// terminal state; pred_dn does the same for the downward terminal. Both are
// computed from the cells' next states, so they are valid in the cycle the
// cells use them. Bit 0 is constantly high (cell 0 always steps). Bit
// NUM_CELLS covers the whole counter and flags the full-width extremes.
// Assumes: the reset value matches a count of zero.
module ladder_predict
    import ladder_counter_pkg::*;
#(
    parameter int NUM_CELLS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cell_t [NUM_CELLS-1:0] state_nxt,
    output logic  [NUM_CELLS:0]   pred_up,
    output logic  [NUM_CELLS:0]   pred_dn
);

    logic [NUM_CELLS-1:0] term_up_nxt;
    logic [NUM_CELLS-1:0] term_dn_nxt;
    logic [NUM_CELLS:1]   pu_nxt;
    logic [NUM_CELLS:1]   pd_nxt;
    logic [NUM_CELLS:1]   pu_q;
    logic [NUM_CELLS:1]   pd_q;

    genvar gi;
    generate
        // Per-cell terminal detection on the next state.
        for (gi = 0; gi < NUM_CELLS; gi++) begin : g_term
            assign term_up_nxt[gi] = (state_nxt[gi] == TERM_UP);
            assign term_dn_nxt[gi] = (state_nxt[gi] == TERM_DN);
        end
        // Per-rung reduction over all lower cells; each is a balanced AND.
        for (gi = 1; gi <= NUM_CELLS; gi++) begin : g_rung
            assign pu_nxt[gi] = &term_up_nxt[gi-1:0];
            assign pd_nxt[gi] = &term_dn_nxt[gi-1:0];
        end
    endgenerate

    // Predict registers; reset state corresponds to every cell at digit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q <= '0;
            pd_q <= '1;
        end else begin
            pu_q <= pu_nxt;
            pd_q <= pd_nxt;
        end
    end

    assign pred_up = {pu_q, 1'b1};
    assign pred_dn = {pd_q, 1'b1};

endmodule

// File: rtl/count_decode.sv
// Translates cell states to a binary count, one 3-bit digit per cell,
// through a per-cell lookup. Purely combinational.
// Assumes: every cell state is one of the 8 states of the cycle.
module count_decode
    import ladder_counter_pkg::*;
#(
    parameter int NUM_CELLS = 6,
    localparam int WIDTH    = NUM_CELLS * CELL_BITS
) (
    input  cell_t [NUM_CELLS-1:0] states,
    output logic  [WIDTH-1:0]     value
);

    genvar gi;
    generate
        // One lookup per digit.
        for (gi = 0; gi < NUM_CELLS; gi++) begin : g_dig
            assign value[gi*CELL_BITS +: CELL_BITS] = cell_dec(states[gi]);
        end
    endgenerate

endmodule

// File: rtl/ladder_updown_counter.sv
// Top: width-independent up/down counter built from a ladder of shift-
// register cells. Cell i steps when enabled and its predict flag for the
// current direction is set; the direction input selects carry or borrow
// per rung. Load maps a binary value into cell states and takes priority.
// carry_o / borrow_o flag the cycle whose edge wraps the full count.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module ladder_updown_counter
    import ladder_counter_pkg::*;
#(
    parameter int NUM_CELLS = 6,
    localparam int WIDTH    = NUM_CELLS * CELL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_up,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_o,
    output logic             borrow_o
);

    cell_t [NUM_CELLS-1:0] cell_state;
    cell_t [NUM_CELLS-1:0] cell_nxt;
    cell_t [NUM_CELLS-1:0] cell_ld;
    logic  [NUM_CELLS-1:0] cell_step;
    logic  [NUM_CELLS:0]   pred_up;
    logic  [NUM_CELLS:0]   pred_dn;
    logic                  advance;

    // A step happens only when enabled and not overridden by a load.
    assign advance = en & ~load;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
            // Binary digit to cell state for the load path.
            assign cell_ld[gi] = cell_enc(load_val[gi*CELL_BITS +: CELL_BITS]);
            // Carry/borrow select for this rung.
            assign cell_step[gi] = advance & (dir_up ? pred_up[gi] : pred_dn[gi]);

            lfsr_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (load),
                .load_state (cell_ld[gi]),
                .step       (cell_step[gi]),
                .dir_up     (dir_up),
                .state      (cell_state[gi]),
                .state_nxt  (cell_nxt[gi])
            );
        end
    endgenerate

    ladder_predict #(.NUM_CELLS(NUM_CELLS)) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (cell_nxt),
        .pred_up   (pred_up),
        .pred_dn   (pred_dn)
    );

    count_decode #(.NUM_CELLS(NUM_CELLS)) u_dec (
        .states (cell_state),
        .value  (count)
    );

    // Full-width wrap flags from the top rung of the ladder.
    assign carry_o  = advance &  dir_up & pred_up[NUM_CELLS];
    assign borrow_o = advance & ~dir_up & pred_dn[NUM_CELLS];

endmodule

// File: rtl/ladder_counter_chk.sv
// Checker for the ladder counter: relates inputs, count and wrap flags over
// consecutive cycles. Attached to the top with the bind at the end.
// Assumes: WIDTH matches the bound instance.
module ladder_counter_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             dir_up,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_o,
    input logic             borrow_o
);

    localparam logic [WIDTH-1:0] TOP = '1;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_up && !load) |=> (count == $past(count) + 1'b1));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dir_up && !load) |=> (count == $past(count) - 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    // R6
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (count == TOP) ##1 (count == '0));

    // R7
    borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_o |-> (count == '0) ##1 (count == TOP));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({carry_o, borrow_o}) <= 1);

endmodule

bind ladder_updown_counter ladder_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .dir_up   (dir_up),
    .load     (load),
    .load_val (load_val),
    .count    (count),
    .carry_o  (carry_o),
    .borrow_o (borrow_o)
);

// File: tb/ladder_updown_counter_test.sv
// Directed bench for the ladder counter: one task per scenario, compared
// every cycle against a plain integer model.
module ladder_updown_counter_test;

    localparam int NUM_CELLS = 6;
    localparam int WIDTH     = NUM_CELLS * 3;
    localparam logic [WIDTH-1:0] TOP = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             dir_up = 1'b1;
    logic             load = 1'b0;
    logic [WIDTH-1:0] load_val = '0;
    logic [WIDTH-1:0] count;
    logic             carry_o;
    logic             borrow_o;

    logic [WIDTH-1:0] model = '0;
    int               total = 0;
    int               bad = 0;
    bit               ended = 1'b0;

    always #2 clk = ~clk;

    ladder_updown_counter #(.NUM_CELLS(NUM_CELLS)) uut (
        .clk (clk), .rst_n (rst_n), .en (en), .dir_up (dir_up),
        .load (load), .load_val (load_val), .count (count),
        .carry_o (carry_o), .borrow_o (borrow_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check the wrap flags, clock, check the count.
    task automatic cyc(input logic e, input logic u, input logic l,
                       input logic [WIDTH-1:0] v, input string tag);
        logic exp_c, exp_b;
        @(negedge clk);
        en = e; dir_up = u; load = l; load_val = v;
        #1;
        exp_c = e && u && !l && (model == TOP);
        exp_b = e && !u && !l && (model == '0);
        check(tag, "carry_o", WIDTH'(carry_o), WIDTH'(exp_c));
        check(tag, "borrow_o", WIDTH'(borrow_o), WIDTH'(exp_b));
        @(posedge clk);
        if (l)      model = v;
        else if (e) model = u ? model + 1'b1 : model - 1'b1;
        #1;
        check(tag, "count", count, model);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; load = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "count in reset", count, '0);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        #1;
        check("R1", "count after release", count, '0);
        check("R1", "carry_o idle", WIDTH'(carry_o), '0);
        check("R1", "borrow_o idle", WIDTH'(borrow_o), '0);
    endtask

    task automatic t_up();
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, '0, "R2");
    endtask

    task automatic t_down();
        cyc(0, 0, 1, WIDTH'(18'h00210), "R5");
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, '0, "R3");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) cyc(0, i[0], 0, '0, "R4");
    endtask

    task automatic t_load();
        cyc(1, 1, 1, WIDTH'(18'h2AAAA), "R5");
        cyc(1, 0, 1, WIDTH'(18'h15555), "R5");
        cyc(0, 1, 1, WIDTH'(18'h3FFF8), "R5");
        cyc(1, 1, 1, WIDTH'(18'h00007), "R5");
        cyc(1, 1, 0, '0, "R5");
    endtask

    task automatic t_wrap_up();
        cyc(0, 1, 1, TOP - 2, "R6");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, '0, "R6");
    endtask

    task automatic t_wrap_down();
        cyc(0, 0, 1, WIDTH'(2), "R7");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, '0, "R7");
    endtask

    task automatic t_flags_quiet();
        cyc(0, 1, 1, TOP, "R9");
        cyc(0, 1, 0, '0, "R9");
        cyc(1, 1, 1, TOP, "R9");
        cyc(1, 0, 0, '0, "R9");
        cyc(0, 0, 1, '0, "R9");
        cyc(0, 0, 0, '0, "R9");
        cyc(1, 0, 1, '0, "R9");
        cyc(1, 1, 0, '0, "R9");
    endtask

    task automatic t_flip();
        logic [WIDTH-1:0] starts [4] = '{WIDTH'(7), WIDTH'(8), WIDTH'(18'h001FF), TOP};
        foreach (starts[k]) begin
            cyc(0, 1, 1, starts[k], "R8");
            cyc(1, 1, 0, '0, "R8");
            cyc(1, 0, 0, '0, "R8");
            cyc(1, 0, 0, '0, "R8");
            cyc(1, 1, 0, '0, "R8");
            cyc(1, 0, 0, '0, "R8");
            cyc(1, 1, 0, '0, "R8");
            cyc(1, 1, 0, '0, "R8");
        end
    endtask

    task automatic t_random();
        logic [WIDTH-1:0] v;
        for (int i = 0; i < 3000; i++) begin
            v = WIDTH'($urandom);
            if ((i % 97) == 0) v = TOP - WIDTH'($urandom_range(0, 3));
            if ((i % 89) == 0) v = WIDTH'($urandom_range(0, 3));
            cyc(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
                ($urandom_range(0, 24) == 0), v, "R8");
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D));
        t_reset();
        t_up();
        t_down();
        t_hold();
        t_load();
        t_wrap_up();
        t_wrap_down();
        t_flags_quiet();
        t_flip();
        t_random();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule